// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block governs when a UART channel may start sending a character and when the far end may send to it. It watches the receive FIFO fill level against a programmable threshold. It drives an active-low handshake output that tells the remote side to stop once the FIFO gets too full, and to resume once the FIFO has drained by a programmable margin. On the transmit side it can hold back new characters while the remote side's active-low handshake input says stop. It can also watch incoming characters for programmable pause and resume codes, which are consumed and not stored. All of these conditions combine into a single transmit permission.

The block sits between the deserializer, the receive FIFO, the transmit FIFO and the transmit shifter. It does not contain any of them. It only decides, cycle by cycle, whether a waiting character may start. It also decides which received characters are forwarded into the receive FIFO. The handshake pair can be either request/clear or terminal-ready/set-ready.

Top module: `uart_flowctl`

## Requirements
- R1: After reset, both handshake outputs are high, `xoff_flag` is 0 and, with automatic transmit gating off, `tx_go` is 1.
- R2: With `cfg_auto_rx` set, the selected handshake output goes high on the clock edge after `rx_fifo_level` is at or above `cfg_trig`.
- R3: With `cfg_auto_rx` set, the selected handshake output goes low on the edge after `rx_fifo_level` falls below the resume mark, and otherwise holds its value. The resume mark is `cfg_trig - cfg_hyst`, or 1 when `cfg_trig <= cfg_hyst`.
- R4: `cfg_pair`=0 selects `rts_n_out`/`cts_n_in` and `cfg_pair`=1 selects `dtr_n_out`/`dsr_n_in`. The unselected output stays high, the unselected input has no effect, and the two outputs are never low together.
- R5: With `cfg_auto_tx` set, `tx_go` follows the selected handshake input through a two-flop synchronizer. It becomes 0 two edges after that input goes high, and becomes 1 again two edges after it goes low, provided no software pause is active.
- R6: Gating acts only on character starts. `tx_start` is high exactly when `tx_req` is high, `tx_busy` is low and `tx_go` is high, so a character that is already shifting is never cut off.
- R7: With `cfg_sw_en` set, a received character equal to `cfg_xoff_char` is not forwarded (`rx_push_valid` low in that cycle), and `tx_go` is 0 from the next edge.
- R8: With `cfg_xon_any` clear, only a character equal to `cfg_xon_char` ends a pause. It is not forwarded. Other characters are forwarded unchanged and leave the pause in place.
- R9: With `cfg_xon_any` set, any received character other than the Xoff code ends a pause from the next edge. An ordinary character that does so is still forwarded.
- R10: `xoff_flag` is set on the edge after an Xoff match. It stays set until an `xoff_flag_clr` pulse, and a match in the same cycle as a clear leaves it set.
- R11: With `cfg_sw_en` clear, every received character is forwarded, including the Xon and Xoff codes, and any software pause ends on the next edge.
- R12: Levels and thresholds span 0 to `FIFO_DEPTH` (64 by default). A level of 63 against a threshold of 64 keeps the output low, and a level of 64 raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_rx | input | 1 | Enable automatic handshake output from FIFO level |
| cfg_auto_tx | input | 1 | Enable transmit gating by the remote handshake input |
| cfg_pair | input | 1 | 0: request/clear pair, 1: terminal-ready/set-ready pair |
| cfg_sw_en | input | 1 | Enable pause/resume character matching |
| cfg_xon_any | input | 1 | Any received character resumes transmission |
| cfg_trig | input | 7 | Receive FIFO stop threshold |
| cfg_hyst | input | 4 | Hysteresis below threshold before resuming (4 typical) |
| cfg_xon_char | input | 8 | Resume character code |
| cfg_xoff_char | input | 8 | Pause character code |
| rx_fifo_level | input | 7 | Current receive FIFO fill level |
| rx_char_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 8 | Received character |
| rx_push_valid | output | 1 | Write the character into the receive FIFO |
| rx_push_data | output | 8 | Character to write into the receive FIFO |
| cts_n_in | input | 1 | Remote clear-to-send, active low, asynchronous |
| dsr_n_in | input | 1 | Remote set-ready, active low, asynchronous |
| rts_n_out | output | 1 | Request-to-send, active low |
| dtr_n_out | output | 1 | Terminal-ready, active low |
| tx_req | input | 1 | Transmit FIFO holds a character to send |
| tx_busy | input | 1 | Shifter is sending a character |
| tx_start | output | 1 | Shifter may load the next character |
| tx_go | output | 1 | Transmit permission after all gating |
| xoff_flag | output | 1 | Sticky pause-character status |
| xoff_flag_clr | input | 1 | Clear pulse for `xoff_flag` |

## Verification
The level path is driven with a rising and falling staircase that crosses the threshold, stops inside the hysteresis band and then drops below it. This separates a correct hold from an output that simply follows the threshold. A threshold smaller than the hysteresis and a threshold equal to the full depth probe the ends of the range. The remote input is toggled while its level is sampled one and two edges later, which shows whether the synchronizer delay is present. The unselected pin is toggled to show it has no effect. The character path is fed Xoff, ordinary and Xon codes in the three modes (exact resume, resume on any character, matching off). Each case distinguishes consumption from forwarding and pause from resume.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic {
    FC_PAIR_REQ_CLR = 1'b0,
    FC_PAIR_TRM_SET = 1'b1
  } fc_pair_e;

  // Level below which the handshake is given back; floor of 1 so an empty
  // FIFO always reopens the link even when the margin swallows the trigger.
  function automatic logic [31:0] fc_resume_mark(input logic [31:0] trig,
                                                 input logic [31:0] hyst);
    return (trig > hyst) ? (trig - hyst) : 32'd1;
  endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int        W       = 2,
  parameter logic      RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_async[i];
        sync_q <= meta_q;
      end
    end
    assign q_sync[i] = sync_q;
  end

endmodule

// File: rtl/fc_rx_gate.sv
module fc_rx_gate
  import fc_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int HYST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  trig,
  input  logic [HYST_W-1:0] hyst,
  output logic              open_q,
  output logic              trip_evt,
  output logic              reopen_evt
);

  logic [31:0] resume_mark;

  always_comb begin
    resume_mark = fc_resume_mark(32'(trig), 32'(hyst));
    trip_evt    = auto_en && (level >= trig);
    reopen_evt  = auto_en && !trip_evt && (32'(level) < resume_mark);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          open_q <= 1'b0;
    else if (trip_evt)   open_q <= 1'b0;
    else if (reopen_evt) open_q <= 1'b1;
  end

endmodule

// File: rtl/fc_char_filter.sv
module fc_char_filter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              xon_any,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              flag_clr,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              paused_q,
  output logic              flag_q,
  output logic              xoff_hit,
  output logic              resume_hit
);

  logic xon_hit, any_hit;

  always_comb begin
    xoff_hit   = sw_en && in_valid && (in_char == xoff_char);
    xon_hit    = sw_en && in_valid && !xoff_hit && (in_char == xon_char);
    any_hit    = sw_en && in_valid && !xoff_hit && xon_any;
    resume_hit = xon_hit || any_hit;
    out_valid  = in_valid && !xoff_hit && !xon_hit;
    out_char   = in_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          paused_q <= 1'b0;
    else if (!sw_en)     paused_q <= 1'b0;
    else if (xoff_hit)   paused_q <= 1'b1;
    else if (resume_hit) paused_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (xoff_hit) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
  import fc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CHAR_W     = 8,
  parameter int HYST_W     = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_rx,
  input  logic              cfg_auto_tx,
  input  logic              cfg_pair,
  input  logic              cfg_sw_en,
  input  logic              cfg_xon_any,
  input  logic [LVL_W-1:0]  cfg_trig,
  input  logic [HYST_W-1:0] cfg_hyst,
  input  logic [CHAR_W-1:0] cfg_xon_char,
  input  logic [CHAR_W-1:0] cfg_xoff_char,
  input  logic [LVL_W-1:0]  rx_fifo_level,
  input  logic              rx_char_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_push_valid,
  output logic [CHAR_W-1:0] rx_push_data,
  input  logic              cts_n_in,
  input  logic              dsr_n_in,
  output logic              rts_n_out,
  output logic              dtr_n_out,
  input  logic              tx_req,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic              tx_go,
  output logic              xoff_flag,
  input  logic              xoff_flag_clr
);

  fc_pair_e   pair_sel;
  logic [1:0] remote_n_sync;
  logic       link_open, trip_evt, reopen_evt;
  logic       sw_paused, xoff_hit, resume_hit;
  logic       remote_ok;

  assign pair_sel = fc_pair_e'(cfg_pair);

  fc_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({dsr_n_in, cts_n_in}),
    .q_sync  (remote_n_sync)
  );

  fc_rx_gate #(.LVL_W(LVL_W), .HYST_W(HYST_W)) u_rx_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (cfg_auto_rx),
    .level      (rx_fifo_level),
    .trig       (cfg_trig),
    .hyst       (cfg_hyst),
    .open_q     (link_open),
    .trip_evt   (trip_evt),
    .reopen_evt (reopen_evt)
  );

  fc_char_filter #(.CHAR_W(CHAR_W)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_en      (cfg_sw_en),
    .xon_any    (cfg_xon_any),
    .xon_char   (cfg_xon_char),
    .xoff_char  (cfg_xoff_char),
    .in_valid   (rx_char_valid),
    .in_char    (rx_char),
    .flag_clr   (xoff_flag_clr),
    .out_valid  (rx_push_valid),
    .out_char   (rx_push_data),
    .paused_q   (sw_paused),
    .flag_q     (xoff_flag),
    .xoff_hit   (xoff_hit),
    .resume_hit (resume_hit)
  );

  always_comb begin
    rts_n_out = 1'b1;
    dtr_n_out = 1'b1;
    remote_ok = 1'b1;
    case (pair_sel)
      FC_PAIR_REQ_CLR: begin
        rts_n_out = !(cfg_auto_rx && link_open);
        remote_ok = !remote_n_sync[0];
      end
      FC_PAIR_TRM_SET: begin
        dtr_n_out = !(cfg_auto_rx && link_open);
        remote_ok = !remote_n_sync[1];
      end
      default: ;
    endcase
    tx_go    = !sw_paused && (!cfg_auto_tx || remote_ok);
    tx_start = tx_req && !tx_busy && tx_go;
  end

endmodule

// File: rtl/fc_checker.sv
module fc_checker
  import fc_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8,
  parameter int HYST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_auto_rx,
  input logic              cfg_auto_tx,
  input logic              cfg_pair,
  input logic              cfg_sw_en,
  input logic              cfg_xon_any,
  input logic [LVL_W-1:0]  cfg_trig,
  input logic [HYST_W-1:0] cfg_hyst,
  input logic [CHAR_W-1:0] cfg_xon_char,
  input logic [CHAR_W-1:0] cfg_xoff_char,
  input logic [LVL_W-1:0]  rx_fifo_level,
  input logic              rx_char_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_push_valid,
  input logic              cts_n_in,
  input logic              rts_n_out,
  input logic              dtr_n_out,
  input logic              tx_go,
  input logic              xoff_flag,
  input logic              xoff_flag_clr
);

  logic xoff_seen, xon_seen;
  assign xoff_seen = cfg_sw_en && rx_char_valid && (rx_char == cfg_xoff_char);
  assign xon_seen  = cfg_sw_en && rx_char_valid && (rx_char == cfg_xon_char)
                     && (rx_char != cfg_xoff_char);

  // R2
  trip_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_rx && !cfg_pair && rx_fifo_level >= cfg_trig) |=> rts_n_out);

  // R3
  resume_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_rx && !cfg_pair &&
     32'(rx_fifo_level) < fc_resume_mark(32'(cfg_trig), 32'(cfg_hyst)) &&
     rx_fifo_level < cfg_trig)
    |=> (!rts_n_out || cfg_pair || !cfg_auto_rx));

  // R4
  pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rts_n_out, dtr_n_out}) >= 1);

  // R5
  remote_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_tx && !cfg_pair && $past(cts_n_in, 2)) |-> !tx_go);

  // R7
  xoff_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_seen |=> !tx_go);

  // R7
  xoff_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_seen |-> !rx_push_valid);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_seen |=> xoff_flag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_flag && !xoff_flag_clr) |=> xoff_flag);

  // R8
  xon_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_seen && !cfg_auto_tx) |=> (tx_go || !cfg_sw_en || cfg_auto_tx));

  // R9
  any_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && cfg_xon_any && rx_char_valid && rx_char != cfg_xoff_char
     && !cfg_auto_tx) |=> (tx_go || cfg_auto_tx || (cfg_sw_en &&
     $past(cfg_sw_en) && 1'b0)));

  // R11
  sw_off_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sw_en && rx_char_valid) |-> rx_push_valid);

endmodule

bind uart_flowctl fc_checker #(.LVL_W(LVL_W), .CHAR_W(CHAR_W), .HYST_W(HYST_W)) u_fc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_auto_rx   (cfg_auto_rx),
  .cfg_auto_tx   (cfg_auto_tx),
  .cfg_pair      (cfg_pair),
  .cfg_sw_en     (cfg_sw_en),
  .cfg_xon_any   (cfg_xon_any),
  .cfg_trig      (cfg_trig),
  .cfg_hyst      (cfg_hyst),
  .cfg_xon_char  (cfg_xon_char),
  .cfg_xoff_char (cfg_xoff_char),
  .rx_fifo_level (rx_fifo_level),
  .rx_char_valid (rx_char_valid),
  .rx_char       (rx_char),
  .rx_push_valid (rx_push_valid),
  .cts_n_in      (cts_n_in),
  .rts_n_out     (rts_n_out),
  .dtr_n_out     (dtr_n_out),
  .tx_go         (tx_go),
  .xoff_flag     (xoff_flag),
  .xoff_flag_clr (xoff_flag_clr)
);

// File: tb/test_uart_flowctl.sv
module test_uart_flowctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_auto_rx = 0, cfg_auto_tx = 0, cfg_pair = 0;
  logic       cfg_sw_en = 0, cfg_xon_any = 0;
  logic [6:0] cfg_trig = 7'd16;
  logic [3:0] cfg_hyst = 4'd4;
  logic [7:0] cfg_xon_char = XON, cfg_xoff_char = XOFF;
  logic [6:0] rx_fifo_level = 0;
  logic       rx_char_valid = 0;
  logic [7:0] rx_char = 0;
  logic       rx_push_valid;
  logic [7:0] rx_push_data;
  logic       cts_n_in = 0, dsr_n_in = 0;
  logic       rts_n_out, dtr_n_out;
  logic       tx_req = 0, tx_busy = 0;
  logic       tx_start, tx_go, xoff_flag;
  logic       xoff_flag_clr = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flowctl i_uart_flowctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_auto_rx(cfg_auto_rx), .cfg_auto_tx(cfg_auto_tx), .cfg_pair(cfg_pair),
    .cfg_sw_en(cfg_sw_en), .cfg_xon_any(cfg_xon_any),
    .cfg_trig(cfg_trig), .cfg_hyst(cfg_hyst),
    .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
    .rx_fifo_level(rx_fifo_level), .rx_char_valid(rx_char_valid), .rx_char(rx_char),
    .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data),
    .cts_n_in(cts_n_in), .dsr_n_in(dsr_n_in),
    .rts_n_out(rts_n_out), .dtr_n_out(dtr_n_out),
    .tx_req(tx_req), .tx_busy(tx_busy), .tx_start(tx_start), .tx_go(tx_go),
    .xoff_flag(xoff_flag), .xoff_flag_clr(xoff_flag_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // Level after which the handshake is released, restated independently.
  function automatic int reopen_below(int trig, int hyst);
    if (trig <= hyst) return 1;
    return trig - hyst;
  endfunction

  task automatic set_level(input int lvl);
    rx_fifo_level = 7'(lvl);
    tick();
  endtask

  // Present one character for one cycle; returns the forwarding seen.
  task automatic send_char(input logic [7:0] c, output logic pushed, output logic [7:0] pdata);
    rx_char_valid = 1'b1;
    rx_char = c;
    #1;
    pushed = rx_push_valid;
    pdata  = rx_push_data;
    tick();
    rx_char_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rts_n", 32'(rts_n_out), 1);
    check("R1 dtr_n", 32'(dtr_n_out), 1);
    check("R1 xoff_flag", 32'(xoff_flag), 0);
    check("R1 tx_go", 32'(tx_go), 1);
  endtask

  task automatic t_threshold;
    cfg_pair = 0; cfg_trig = 7'd16; cfg_hyst = 4'd4; cfg_auto_rx = 1;
    set_level(0);
    check("R3 open when empty", 32'(rts_n_out), 0);
    set_level(15);
    check("R2 below trigger stays low", 32'(rts_n_out), 0);
    set_level(16);
    check("R2 at trigger goes high", 32'(rts_n_out), 1);
    check("R4 unselected dtr high", 32'(dtr_n_out), 1);
    set_level(14);
    check("R3 hold inside band", 32'(rts_n_out), 1);
    set_level(reopen_below(16, 4));
    check("R3 hold at resume mark", 32'(rts_n_out), 1);
    set_level(reopen_below(16, 4) - 1);
    check("R3 reopen below mark", 32'(rts_n_out), 0);
  endtask

  task automatic t_small_trig;
    cfg_trig = 7'd3; cfg_hyst = 4'd4;
    set_level(3);
    check("R2 small trigger", 32'(rts_n_out), 1);
    set_level(1);
    check("R3 floor mark holds at 1", 32'(rts_n_out), 1);
    set_level(0);
    check("R3 floor mark reopens at 0", 32'(rts_n_out), 0);
  endtask

  task automatic t_full;
    cfg_trig = 7'd64; cfg_hyst = 4'd4;
    set_level(63);
    check("R12 level 63 of 64", 32'(rts_n_out), 0);
    set_level(64);
    check("R12 level 64 of 64", 32'(rts_n_out), 1);
    set_level(0);
  endtask

  task automatic t_pair;
    cfg_pair = 1; cfg_trig = 7'd8;
    set_level(0);
    check("R4 dtr low when selected", 32'(dtr_n_out), 0);
    check("R4 rts high when unselected", 32'(rts_n_out), 1);
    set_level(8);
    check("R4 dtr high at trigger", 32'(dtr_n_out), 1);
    set_level(0);
    cfg_auto_rx = 0;
    tick();
    check("R4 dtr released when auto off", 32'(dtr_n_out), 1);
    cfg_pair = 0;
  endtask

  task automatic t_remote;
    cts_n_in = 0; dsr_n_in = 0; cfg_pair = 0;
    tick(); tick();
    cfg_auto_tx = 1; tx_req = 1; tx_busy = 0;
    #1;
    check("R6 start when allowed", 32'(tx_start), 1);
    cts_n_in = 1;
    tick();
    check("R5 one edge still allowed", 32'(tx_go), 1);
    tick();
    check("R5 two edges blocked", 32'(tx_go), 0);
    check("R6 no start when blocked", 32'(tx_start), 0);
    dsr_n_in = 1; tick(); tick();
    dsr_n_in = 0; tick(); tick();
    check("R4 unselected input no effect", 32'(tx_go), 0);
    cts_n_in = 0;
    tick();
    check("R5 one edge still blocked", 32'(tx_go), 0);
    tick();
    check("R5 resumed", 32'(tx_go), 1);
    check("R6 pending request starts", 32'(tx_start), 1);
    tx_busy = 1;
    #1;
    check("R6 no start while busy", 32'(tx_start), 0);
    tx_busy = 0; tx_req = 0; cfg_auto_tx = 0;
    tick();
  endtask

  task automatic t_xoff_xon;
    logic p; logic [7:0] d;
    cfg_sw_en = 1; cfg_xon_any = 0;
    send_char(XOFF, p, d);
    check("R7 xoff not forwarded", 32'(p), 0);
    check("R7 paused after xoff", 32'(tx_go), 0);
    check("R10 flag set", 32'(xoff_flag), 1);
    send_char(8'h41, p, d);
    check("R8 ordinary forwarded", 32'(p), 1);
    check("R8 ordinary data", 32'(d), 32'h41);
    check("R8 ordinary keeps pause", 32'(tx_go), 0);
    send_char(XON, p, d);
    check("R8 xon not forwarded", 32'(p), 0);
    check("R8 xon resumes", 32'(tx_go), 1);
    check("R10 flag sticky", 32'(xoff_flag), 1);
    xoff_flag_clr = 1; tick(); xoff_flag_clr = 0;
    check("R10 flag cleared", 32'(xoff_flag), 0);
    xoff_flag_clr = 1;
    send_char(XOFF, p, d);
    xoff_flag_clr = 0;
    check("R10 set wins over clear", 32'(xoff_flag), 1);
    send_char(XON, p, d);
  endtask

  task automatic t_xon_any;
    logic p; logic [7:0] d;
    cfg_xon_any = 1;
    send_char(XOFF, p, d);
    check("R7 paused in any mode", 32'(tx_go), 0);
    send_char(XOFF, p, d);
    check("R9 second xoff keeps pause", 32'(tx_go), 0);
    send_char(8'h42, p, d);
    check("R9 any char forwarded", 32'(p), 1);
    check("R9 any char data", 32'(d), 32'h42);
    check("R9 any char resumes", 32'(tx_go), 1);
    cfg_xon_any = 0;
  endtask

  task automatic t_sw_off;
    logic p; logic [7:0] d;
    send_char(XOFF, p, d);
    check("R7 paused before disable", 32'(tx_go), 0);
    cfg_sw_en = 0;
    tick();
    check("R11 pause ends when off", 32'(tx_go), 1);
    send_char(XOFF, p, d);
    check("R11 xoff forwarded when off", 32'(p), 1);
    check("R11 no pause when off", 32'(tx_go), 1);
    send_char(XON, p, d);
    check("R11 xon forwarded when off", 32'(p), 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_threshold();
    t_small_trig();
    t_full();
    t_pair();
    t_remote();
    t_xoff_xon();
    t_xon_any();
    t_sw_off();
    tick();
    finish_run();
  end

endmodule